// File: doc/BRIEF.md
# Stereo Serial Audio Output Port

This block takes left and right audio samples as parallel words, each qualified by a valid strobe. It sends them out MSB first on a serial data line, next to a bit clock, a word clock and a frame-sync line. Four framings are supported: left-justified 20-bit, I2S 20-bit, right-justified 16-bit and right-justified 20-bit. The framing is chosen with a two-bit format input. A two-bit mode input chooses between slave operation and master operation at one of three system-clock ratios.

In master mode the port derives the bit clock, word clock and frame sync from the system clock `clk`, which runs at 256, 384 or 512 times the sample rate. It drives all three clocks and raises `clocks_oe`. In slave mode all three clocks come in from outside. They are resynchronised to `clk`, and a data bit is shifted out only while the incoming frame sync is high. Both samples of a frame are taken from the holding registers at the start of the left channel, so left and right always come from the same update. The format and mode inputs are sampled only while reset is asserted. The values present in the last reset cycle stay in force until the next reset.

Top module: `stereo_serial_out`

## Requirements
- R1: Format code 00 gives a 20-bit data window starting at bit slot 0 of each channel, with the word clock high for left. Code 11 gives a 20-bit window starting at slot 12, also with the word clock high for left.
- R2: Format code 01 (I2S) gives a 20-bit window starting at slot 1, one bit clock after the word-clock edge, with the word clock low for the left channel.
- R3: In master mode, mode code 01 gives a bit clock period of 8 `clk` cycles, code 10 gives 6 and code 11 gives 4. Every channel holds 32 bit slots, so one word-clock period is 64 bit clocks.
- R4: Format code 10 sends a 16-bit window starting at slot 16, made of sample bits 19 down to 4. The 4 LSBs are dropped.
- R5: Mode code 00 is slave mode. `clocks_oe` is 0, the three clock outputs stay 0, and a data bit is shifted out only on bit slots where `fsync_i` is high. The bits are counted from the start of the channel and capped at the format's data length.
- R6: In master mode, the word clock, the frame sync and the serial data change only after a falling edge of the bit clock. They are stable at each rising edge.
- R7: The serial data line is 0 on every bit slot outside the active data bits.
- R8: In master mode the frame sync is high exactly on the data bits of each channel, which is twice per word-clock period.
- R9: Format and mode are sampled only while `rst` is high. Changes after reset is released have no effect.
- R10: While `rst` is high, all outputs are 0.
- R11: A sample pair written with `smp_valid` appears on the line from the next left-channel start onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256/384/512 x sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing select, sampled during reset |
| mode_sel | input | 2 | Slave/master ratio select, sampled during reset |
| smp_l | input | 20 | Left sample |
| smp_r | input | 20 | Right sample |
| smp_valid | input | 1 | Loads the sample pair into the holding registers |
| bclk_i | input | 1 | Bit clock in (slave) |
| wclk_i | input | 1 | Word clock in (slave) |
| fsync_i | input | 1 | Frame sync in (slave), gates shifting |
| bclk_o | output | 1 | Bit clock out (master) |
| wclk_o | output | 1 | Word clock out (master) |
| fsync_o | output | 1 | Frame sync out (master) |
| clocks_oe | output | 1 | High when the port drives the three clocks |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
Some properties are checked by assertions on every cycle. Word-clock and frame-sync changes must line up with a bit-clock fall (R6, R8). The data line may change only in the cycle after a slot tick (R6). A slot with frame sync low must leave the data line at 0 (R7). The generator must stay idle in slave mode (R5). Other behaviour can only be shown by the bench scenarios: window position and length for each format, word-clock polarity, LSB truncation, bit-clock period for each ratio, configuration held across reset release, and slave gating with an arbitrary frame-sync window. The bench decodes whole frames for these.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    FMT_LJ   = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ20 = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    MODE_SLAVE = 2'b00,
    MODE_M512  = 2'b01,
    MODE_M384  = 2'b10,
    MODE_M256  = 2'b11
  } mode_e;
endpackage

// File: rtl/sop_clkgen.sv
module sop_clkgen
  import sop_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 20,
  parameter int SHORT_W  = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  fmt_e  fmt,
  input  mode_e mode,
  output logic  bck_o,
  output logic  lrck_o,
  output logic  fs_o,
  output logic  tick_o
);
  localparam int SLOT_W = $clog2(2 * SLOTS);
  localparam int CH_W   = SLOT_W - 1;
  localparam int H512   = 512 / (4 * SLOTS);
  localparam int H384   = 384 / (4 * SLOTS);
  localparam int H256   = 256 / (4 * SLOTS);
  localparam int DIV_W  = $clog2(H512 + 1);

  logic [DIV_W-1:0]  div_q, half_m1;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [CH_W-1:0]   sc_n;
  int                win_st, win_len;
  logic              fs_n, lr_n;

  always_comb begin
    case (mode)
      MODE_M512: half_m1 = DIV_W'(H512 - 1);
      MODE_M384: half_m1 = DIV_W'(H384 - 1);
      default:   half_m1 = DIV_W'(H256 - 1);
    endcase
    case (fmt)
      FMT_LJ:   begin win_st = 0;                win_len = SAMPLE_W; end
      FMT_I2S:  begin win_st = 1;                win_len = SAMPLE_W; end
      FMT_RJ16: begin win_st = SLOTS - SHORT_W;  win_len = SHORT_W;  end
      default:  begin win_st = SLOTS - SAMPLE_W; win_len = SAMPLE_W; end
    endcase
    slot_n = slot_q + 1'b1;
    sc_n   = slot_n[CH_W-1:0];
    fs_n   = (int'(sc_n) >= win_st) && (int'(sc_n) < win_st + win_len);
    // first half of the word period is the left channel
    lr_n   = ~slot_n[SLOT_W-1] ^ (fmt == FMT_I2S);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q  <= '0;
      bck_o  <= 1'b0;
      slot_q <= '1;
      lrck_o <= 1'b0;
      fs_o   <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (div_q == half_m1) begin
        div_q <= '0;
        bck_o <= ~bck_o;
        if (bck_o) begin
          slot_q <= slot_n;
          lrck_o <= lr_n;
          fs_o   <= fs_n;
          tick_o <= 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_WCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $fell(bck_o)); // R6
  AST_FSYNC_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(fs_o) |-> $fell(bck_o)); // R8
endmodule

// File: rtl/sop_slave_sync.sv
module sop_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic lr_i,
  input  logic fs_i,
  output logic tick_o,
  output logic lr_o,
  output logic fs_o
);
  logic [2:0] pipe_q [STAGES];
  logic       bck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      bck_d <= 1'b0;
    end else begin
      pipe_q[0] <= {bck_i, lr_i, fs_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      bck_d <= pipe_q[STAGES-1][2];
    end
  end

  assign tick_o = bck_d & ~pipe_q[STAGES-1][2];
  assign lr_o   = pipe_q[STAGES-1][1];
  assign fs_o   = pipe_q[STAGES-1][0];
endmodule

// File: rtl/sop_shifter.sv
module sop_shifter
  import sop_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  fmt_e                fmt,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic                smp_valid,
  input  logic                tick,
  input  logic                lr,
  input  logic                fs,
  output logic                dout_o
);
  localparam int IDX_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] hold_l, hold_r, rsh_q, cur_q, word_now, sh;
  logic [IDX_W-1:0]    idx_q, idx_now, len;
  logic                cur_left, is_left, start;

  always_comb begin
    len      = (fmt == FMT_RJ16) ? IDX_W'(SHORT_W) : IDX_W'(SAMPLE_W);
    is_left  = lr ^ (fmt == FMT_I2S);
    start    = is_left != cur_left;
    word_now = start ? (is_left ? hold_l : rsh_q) : cur_q;
    idx_now  = start ? '0 : idx_q;
    sh       = word_now << idx_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l   <= '0;
      hold_r   <= '0;
      rsh_q    <= '0;
      cur_q    <= '0;
      idx_q    <= '0;
      cur_left <= 1'b0;
      dout_o   <= 1'b0;
    end else begin
      if (smp_valid) begin
        hold_l <= smp_l;
        hold_r <= smp_r;
      end
      if (tick) begin
        cur_left <= is_left;
        cur_q    <= word_now;
        if (start && is_left) rsh_q <= hold_r;
        if (fs && (idx_now < len)) begin
          dout_o <= sh[SAMPLE_W-1];
          idx_q  <= idx_now + 1'b1;
        end else begin
          dout_o <= 1'b0;
          idx_q  <= idx_now;
        end
      end
    end
  end

  AST_DOUT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_o) |-> $past(tick)); // R6
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (tick && !fs) |=> !dout_o); // R7
endmodule

// File: rtl/stereo_serial_out.sv
module stereo_serial_out
  import sop_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SHORT_W     = 16,
  parameter int SLOTS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          mode_sel,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic                smp_valid,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                fsync_i,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                fsync_o,
  output logic                clocks_oe,
  output logic                sdata_o
);
  logic [1:0] fmt_q, mode_q;
  logic       master;
  logic       g_bck, g_lr, g_fs, g_tick;
  logic       s_tick, s_lr, s_fs;
  logic       tick, lr, fs;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= fmt_sel;
      mode_q <= mode_sel;
    end
  end

  assign master = (mode_q != MODE_SLAVE);

  sop_clkgen #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_gen (
    .clk(clk), .rst(rst), .en(master),
    .fmt(fmt_e'(fmt_q)), .mode(mode_e'(mode_q)),
    .bck_o(g_bck), .lrck_o(g_lr), .fs_o(g_fs), .tick_o(g_tick)
  );

  sop_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck_i(bclk_i), .lr_i(wclk_i), .fs_i(fsync_i),
    .tick_o(s_tick), .lr_o(s_lr), .fs_o(s_fs)
  );

  assign tick = master ? g_tick : s_tick;
  assign lr   = master ? g_lr   : s_lr;
  assign fs   = master ? g_fs   : s_fs;

  sop_shifter #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_shift (
    .clk(clk), .rst(rst), .fmt(fmt_e'(fmt_q)),
    .smp_l(smp_l), .smp_r(smp_r), .smp_valid(smp_valid),
    .tick(tick), .lr(lr), .fs(fs), .dout_o(sdata_o)
  );

  assign bclk_o    = master & g_bck;
  assign wclk_o    = master & g_lr;
  assign fsync_o   = master & g_fs;
  assign clocks_oe = master & ~rst;

  AST_SLAVE_GEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !master |-> (!g_bck && !g_tick)); // R5
endmodule

// File: tb/tb_stereo_serial_out.sv
`timescale 1ns/1ps
module tb_stereo_serial_out;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'b00, mode_sel = 2'b00;
  logic [19:0] smp_l = '0, smp_r = '0;
  logic        smp_valid = 1'b0;
  logic        bclk_i = 1'b0, wclk_i = 1'b0, fsync_i = 1'b0;
  logic        bclk_o, wclk_o, fsync_o, clocks_oe, sdata_o;

  int nvec = 0, nerr = 0;
  int cyc  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stereo_serial_out dut (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .mode_sel(mode_sel),
    .smp_l(smp_l), .smp_r(smp_r), .smp_valid(smp_valid),
    .bclk_i(bclk_i), .wclk_i(wclk_i), .fsync_i(fsync_i),
    .bclk_o(bclk_o), .wclk_o(wclk_o), .fsync_o(fsync_o),
    .clocks_oe(clocks_oe), .sdata_o(sdata_o)
  );

  // frame decoder on the master-mode outputs
  bit mon_i2s = 0;
  int chan_cnt, slot, nb, st, zb, per, last_rise;
  bit have, cur_l, pb;
  logic [31:0] rx;
  logic [31:0] ll_word, rr_word;
  int ll_nb, rr_nb, ll_st, rr_st, ll_sl, rr_sl, ll_zb, rr_zb;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      chan_cnt = 0; have = 0; pb = 0; per = 0; last_rise = cyc;
    end else begin
      if (!pb && bclk_o) begin
        bit il;
        per = cyc - last_rise; last_rise = cyc;
        il = wclk_o ^ mon_i2s;
        if (!have || il != cur_l) begin
          if (have) begin
            if (cur_l) begin ll_word = rx; ll_nb = nb; ll_st = st; ll_sl = slot; ll_zb = zb; end
            else       begin rr_word = rx; rr_nb = nb; rr_st = st; rr_sl = slot; rr_zb = zb; end
            chan_cnt++;
          end
          have = 1; cur_l = il; slot = 0; rx = '0; nb = 0; st = 99; zb = 0;
        end
        if (fsync_o) begin
          if (nb == 0) st = slot;
          rx = {rx[30:0], sdata_o};
          nb++;
        end else if (sdata_o) zb++;
        slot++;
      end
      pb = bclk_o;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_start(input logic [1:0] f);
    case (f) 2'b00: return 0; 2'b01: return 1; 2'b10: return 16; default: return 12; endcase
  endfunction
  function automatic int exp_len(input logic [1:0] f);
    return (f == 2'b10) ? 16 : 20;
  endfunction

  task automatic do_reset(input logic [1:0] md, input logic [1:0] fm);
    @(negedge clk);
    rst = 1'b1; mode_sel = md; fmt_sel = fm; mon_i2s = (fm == 2'b01);
    bclk_i = 0; wclk_i = 0; fsync_i = 0;
    repeat (4) @(negedge clk);
    check("R10 reset outputs", {bclk_o, wclk_o, fsync_o, clocks_oe, sdata_o}, 5'b0);
    rst = 1'b0;
  endtask

  task automatic load(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk); smp_l = l; smp_r = r; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic wait_chans(input int n);
    for (int i = 0; i < 20000 && chan_cnt < n; i++) @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input logic [1:0] fm,
                             input logic [19:0] l, input logic [19:0] r);
    int ln = exp_len(fm);
    check({tag, " left word"},  ll_word, 32'(l >> (20 - ln)));
    check({tag, " right word"}, rr_word, 32'(r >> (20 - ln)));
    check({tag, " left nbits R8"},  ll_nb, ln);
    check({tag, " right nbits R8"}, rr_nb, ln);
    check({tag, " left start"},  ll_st, exp_start(fm));
    check({tag, " right start"}, rr_st, exp_start(fm));
    check({tag, " slots R3"}, ll_sl + rr_sl, 64);
    check({tag, " zero outside R7"}, ll_zb + rr_zb, 0);
  endtask

  task automatic run_master(input string tag, input logic [1:0] md, input logic [1:0] fm,
                            input logic [19:0] l, input logic [19:0] r, input int bper);
    do_reset(md, fm);
    load(l, r);
    wait_chans(6);
    check({tag, " clocks_oe R3"}, clocks_oe, 1);
    check({tag, " bclk period R3"}, per, bper);
    check_frame(tag, fm, l, r);
  endtask

  task automatic test_lj_512();   run_master("R1 LJ/512",   2'b01, 2'b00, 20'hA5C3F, 20'h1E2D4, 8); endtask
  task automatic test_i2s_384();  run_master("R2 I2S/384",  2'b10, 2'b01, 20'h80001, 20'h7FFFE, 6); endtask
  task automatic test_rj16_256(); run_master("R4 RJ16/256", 2'b11, 2'b10, 20'hF00FA, 20'h5A5A5, 4); endtask
  task automatic test_rj20_512(); run_master("R1 RJ20/512", 2'b01, 2'b11, 20'h3C96E, 20'hC3691, 8); endtask

  task automatic test_cfg_hold();
    do_reset(2'b01, 2'b00);
    @(negedge clk); mode_sel = 2'b00; fmt_sel = 2'b01;
    load(20'h12345, 20'h6789A);
    wait_chans(6);
    check("R9 mode kept: oe", clocks_oe, 1);
    check("R9 mode kept: period", per, 8);
    check_frame("R9 format kept", 2'b00, 20'h12345, 20'h6789A);
  endtask

  task automatic test_update();
    int c0;
    do_reset(2'b11, 2'b00);
    load(20'h0F0F0, 20'hF0F0F);
    wait_chans(6);
    check_frame("R11 first", 2'b00, 20'h0F0F0, 20'hF0F0F);
    load(20'hABCDE, 20'h13579);
    c0 = chan_cnt;
    wait_chans(c0 + 5);
    check_frame("R11 updated", 2'b00, 20'hABCDE, 20'h13579);
  endtask

  task automatic slave_channel(input string tag, input bit lvl, input int lo, input int hi,
                               input logic [19:0] w, input int cap, input bit chk);
    logic [31:0] got = '0, exp = '0;
    int bad = 0;
    for (int s = 0; s < 32; s++) begin
      bit f;
      int k;
      f = (s >= lo) && (s < hi);
      k = s - lo;
      @(negedge clk); bclk_i = 0; wclk_i = lvl; fsync_i = f;
      repeat (8) @(negedge clk);
      got = {got[30:0], sdata_o};
      exp = {exp[30:0], (f && k < cap) ? w[19-k] : 1'b0};
      if (clocks_oe || bclk_o || wclk_o || fsync_o) bad++;
      bclk_i = 1;
      repeat (7) @(negedge clk);
    end
    if (chk) begin
      check({tag, " slot data R5 R7"}, got, exp);
      check({tag, " clocks not driven R5"}, bad, 0);
    end
  endtask

  task automatic test_slave_lj();
    do_reset(2'b00, 2'b00);
    load(20'hC1A57, 20'h2B6E9);
    slave_channel("R5 LJ pre",   1'b0, 0, 20, 20'h0, 20, 1'b0);
    slave_channel("R5 LJ left",  1'b1, 0, 20, 20'hC1A57, 20, 1'b1);
    slave_channel("R5 LJ right", 1'b0, 0, 20, 20'h2B6E9, 20, 1'b1);
  endtask

  task automatic test_slave_window();
    do_reset(2'b00, 2'b01);
    load(20'h9D3B1, 20'h64E2C);
    slave_channel("R5 I2S pre",   1'b1, 4, 14, 20'h0, 20, 1'b0);
    slave_channel("R5 I2S left",  1'b0, 4, 14, 20'h9D3B1, 20, 1'b1);
    slave_channel("R5 I2S right", 1'b1, 4, 14, 20'h64E2C, 20, 1'b1);
  endtask

  task automatic test_slave_cap();
    do_reset(2'b00, 2'b10);
    load(20'hFFFFF, 20'hE7DB5);
    slave_channel("R4 RJ16 slave pre",   1'b0, 8, 32, 20'h0, 16, 1'b0);
    slave_channel("R4 RJ16 slave left",  1'b1, 8, 32, 20'hFFFFF, 16, 1'b1);
    slave_channel("R4 RJ16 slave right", 1'b0, 8, 32, 20'hE7DB5, 16, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    test_lj_512();
    test_i2s_384();
    test_rj16_256();
    test_rj20_512();
    test_cfg_hold();
    test_update();
    test_slave_lj();
    test_slave_window();
    test_slave_cap();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule